// File: doc/BRIEF.md
# Vector Absolute Difference Unit

This block is an execute-stage functional unit with its own small vector register file. It performs one destructive two-operand instruction. For two register indices, t and r, it subtracts vector t from vector r lane by lane, takes the magnitude of each lane difference, and writes the result over register t. Both the subtraction and the magnitude finish within a single execute cycle. The instruction serves as the inner step of motion-estimation loops that sum absolute pixel differences. Summing the lane results is left to other logic.

Each vector holds four 8-bit unsigned pixel lanes. Registers are preloaded through an external write port, and any register can be inspected through a combinational read port. An instruction and an external write can arrive in the same cycle. In that case the instruction owns the register file and the external write is dropped.

Top module: `vadiff_unit`

## Requirements
- R1: After reset, all four vector registers read back as zero.
- R2: When `wr_en` is high and `op_valid` is low, `wr_data` is stored in register `wr_idx` at the clock edge. All other registers keep their values.
- R3: Lane k occupies bits [8k+7:8k] of a vector. An instruction stores |V[r] lane k − V[t] lane k| into lane k of V[t]. The subtraction is exact over 9 bits, so each result lane is an 8-bit value in the range 0 to 255.
- R4: When t differs from r, an instruction leaves V[r] and every register other than V[t] unchanged.
- R5: An instruction with t equal to r sets every lane of V[t] to zero.
- R6: When `op_valid` and `wr_en` are high in the same cycle, the external write is discarded, whatever `wr_idx` is. Only the instruction result is stored.
- R7: The read port is combinational. A read of V[t] in the cycle after an instruction returns the updated value.
- R8: When neither `op_valid` nor `wr_en` is high, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction strobe for the current cycle |
| op_t | input | 2 | Index t: subtrahend source and destination |
| op_r | input | 2 | Index r: minuend source |
| wr_en | input | 1 | External write request |
| wr_idx | input | 2 | External write register index |
| wr_data | input | 32 | External write data, four 8-bit lanes |
| rd_idx | input | 2 | Read port register index |
| rd_data | output | 32 | Contents of register rd_idx |

## Verification
Every register update, whether from an instruction or an external write, takes effect at the rising edge that samples the request. The new value then appears on `rd_data` as soon as `rd_idx` selects that register, with no added latency. The bench drives requests on the falling edge and lets exactly one rising edge pass. On the following falling edge it sets `rd_idx` and samples one time unit later, so each check observes the first cycle in which the result is due. The main sweep covers every 8-bit minuend against every 8-bit subtrahend across changing register pairs. It compares each destination register and each untouched source register against an arithmetic model kept in the bench.

// File: rtl/vadiff_pkg.sv
package vadiff_pkg;

  // Source that owns the register-file write port in a given cycle
  typedef enum logic [1:0] {
    WSRC_NONE = 2'd0,
    WSRC_EXEC = 2'd1,
    WSRC_EXT  = 2'd2
  } wsrc_e;

endpackage

// File: rtl/vadiff_regfile.sv
module vadiff_regfile #(
  parameter int NUM_REGS = 4,
  parameter int VEC_W    = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [VEC_W-1:0] wdata,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [VEC_W-1:0] ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [VEC_W-1:0] rb_data,
  input  logic [IDX_W-1:0] rc_idx,
  output logic [VEC_W-1:0] rc_data
);

  logic [NUM_REGS-1:0][VEC_W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
  assign rc_data = mem[rc_idx];

  // R3
  wb_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(widx)] == $past(wdata));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));

endmodule

// File: rtl/vadiff_lane.sv
module vadiff_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] minuend,
  input  logic [LANE_W-1:0] subtrahend,
  output logic [LANE_W-1:0] mag
);

  // Exact |x - y| using one extra bit for the sign of the difference
  function automatic logic [LANE_W-1:0] abs_gap(input logic [LANE_W-1:0] x,
                                                input logic [LANE_W-1:0] y);
    logic [LANE_W:0] wide;
    logic [LANE_W:0] neg;
    wide = {1'b0, x} - {1'b0, y};
    neg  = -wide;
    return wide[LANE_W] ? neg[LANE_W-1:0] : wide[LANE_W-1:0];
  endfunction

  assign mag = abs_gap(minuend, subtrahend);

endmodule

// File: rtl/vadiff_datapath.sv
module vadiff_datapath #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0] vec_t,
  input  logic [VEC_W-1:0] vec_r,
  output logic [VEC_W-1:0] vec_out
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vadiff_lane #(.LANE_W(LANE_W)) i_lane (
      .minuend    (vec_r[k*LANE_W +: LANE_W]),
      .subtrahend (vec_t[k*LANE_W +: LANE_W]),
      .mag        (vec_out[k*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/vadiff_unit.sv
module vadiff_unit #(
  parameter int NUM_REGS = 4,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int VEC_W   = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [IDX_W-1:0] op_t,
  input  logic [IDX_W-1:0] op_r,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VEC_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VEC_W-1:0] rd_data
);

  import vadiff_pkg::*;

  logic [VEC_W-1:0] src_t;
  logic [VEC_W-1:0] src_r;
  logic [VEC_W-1:0] result;

  // Named events for the write-port arbitration
  logic  exec_fire;
  logic  ext_fire;
  wsrc_e wsrc;

  logic             wf_en;
  logic [IDX_W-1:0] wf_idx;
  logic [VEC_W-1:0] wf_data;

  assign exec_fire = op_valid;
  assign ext_fire  = wr_en && !op_valid;

  always_comb begin
    if (exec_fire)     wsrc = WSRC_EXEC;
    else if (ext_fire) wsrc = WSRC_EXT;
    else               wsrc = WSRC_NONE;
  end

  always_comb begin
    wf_en   = 1'b0;
    wf_idx  = '0;
    wf_data = '0;
    case (wsrc)
      WSRC_EXEC: begin
        wf_en   = 1'b1;
        wf_idx  = op_t;
        wf_data = result;
      end
      WSRC_EXT: begin
        wf_en   = 1'b1;
        wf_idx  = wr_idx;
        wf_data = wr_data;
      end
      default: ;
    endcase
  end

  vadiff_regfile #(.NUM_REGS(NUM_REGS), .VEC_W(VEC_W)) i_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wf_en),
    .widx    (wf_idx),
    .wdata   (wf_data),
    .ra_idx  (op_t),
    .ra_data (src_t),
    .rb_idx  (op_r),
    .rb_data (src_r),
    .rc_idx  (rd_idx),
    .rc_data (rd_data)
  );

  vadiff_datapath #(.LANES(LANES), .LANE_W(LANE_W)) i_datapath (
    .vec_t   (src_t),
    .vec_r   (src_r),
    .vec_out (result)
  );

  // R5
  same_reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_t == op_r) |-> result == '0);

  // R6
  ext_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wr_en) |-> (wf_idx == op_t && wf_data == result));

  for (genvar k = 0; k < LANES; k++) begin : g_bound
    // R3
    lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (result[k*LANE_W +: LANE_W] <= src_r[k*LANE_W +: LANE_W] ||
                    result[k*LANE_W +: LANE_W] <= src_t[k*LANE_W +: LANE_W]));
  end

endmodule

// File: tb/test_vadiff_unit.sv
module test_vadiff_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_t = '0;
  logic [1:0]  op_r = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [4];

  always #2.5 clk = ~clk;

  vadiff_unit i_vadiff_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_t(op_t), .op_r(op_r),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic [31:0] ref_absdiff(input logic [31:0] vr, input logic [31:0] vt);
    logic [31:0] o;
    for (int k = 0; k < 4; k++) begin
      int d;
      d = int'(vr[8*k +: 8]) - int'(vt[8*k +: 8]);
      if (d < 0) d = -d;
      o[8*k +: 8] = 8'(d);
    end
    return o;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_reg(input int idx, input string req);
    rd_idx = 2'(idx);
    #1;
    checks++;
    if (rd_data !== model[idx]) begin
      errors++;
      $display("FAIL %s reg %0d actual %h expected %h", req, idx, rd_data, model[idx]);
    end
  endtask

  task automatic ext_write(input int idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_data = d;
    tick();
    wr_en = 1'b0;
    model[idx] = d;
  endtask

  task automatic issue(input int t, input int r);
    op_valid = 1'b1; op_t = 2'(t); op_r = 2'(r);
    tick();
    op_valid = 1'b0;
    model[t] = ref_absdiff(model[r], model[t]);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 4; i++) check_reg(i, "R1");

    // R2: load each register with a distinct pattern
    ext_write(0, 32'h0102_0304);
    ext_write(1, 32'hF0E0_D0C0);
    ext_write(2, 32'h5566_7788);
    ext_write(3, 32'h00FF_80_7F);
    for (int i = 0; i < 4; i++) check_reg(i, "R2");

    // R8: idle cycles with a busy-looking write bus
    wr_data = 32'hDEAD_BEEF; wr_idx = 2'd1;
    repeat (5) tick();
    for (int i = 0; i < 4; i++) check_reg(i, "R8");

    // R7: destination read in the very next cycle
    issue(1, 0);
    check_reg(1, "R7");
    check_reg(0, "R4");

    // R5: t equal to r clears the register
    issue(2, 2);
    check_reg(2, "R5");

    // R6: simultaneous external write to another register is dropped
    ext_write(3, 32'h1122_3344);
    op_valid = 1'b1; op_t = 2'd0; op_r = 2'd1;
    wr_en = 1'b1; wr_idx = 2'd3; wr_data = 32'hCAFE_F00D;
    tick();
    op_valid = 1'b0; wr_en = 1'b0;
    model[0] = ref_absdiff(model[1], model[0]);
    check_reg(3, "R6");
    check_reg(0, "R6");

    // R6: simultaneous external write to the destination loses
    op_valid = 1'b1; op_t = 2'd1; op_r = 2'd3;
    wr_en = 1'b1; wr_idx = 2'd1; wr_data = 32'hAAAA_AAAA;
    tick();
    op_valid = 1'b0; wr_en = 1'b0;
    model[1] = ref_absdiff(model[3], model[1]);
    check_reg(1, "R6");

    // R3 / R4: every minuend against every subtrahend over rotating pairs
    for (int a = 0; a < 256; a++) begin
      for (int bb = 0; bb < 64; bb++) begin
        int t;
        int r;
        logic [7:0] av;
        logic [31:0] bv;
        t = (a + bb) % 4;
        r = (t + 1 + (bb % 3)) % 4;
        av = 8'(a);
        bv = {8'(4*bb + 3), 8'(4*bb + 2), 8'(4*bb + 1), 8'(4*bb)};
        ext_write(t, {4{av}});
        ext_write(r, bv);
        issue(t, r);
        check_reg(t, "R3");
        check_reg(r, "R4");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule